// File: doc/BRIEF.md
# I2C Byte Master with Register Interface

This block drives an I2C bus as the only master, one byte at a time, under control of a small bank of 8-bit registers on a simple synchronous bus. Software loads a 16-bit clock divider, turns the core on, puts a byte in the data register and then writes one command byte. That byte may ask for a start condition, a write, a read, an acknowledge choice and a stop condition, all at once. The core runs the requested bus sequence on the open-drain SCL and SDA lines, records the acknowledge bit, and sets an interrupt flag when the sequence is done.

Each bit on the bus takes five divider ticks. A tick comes every prescale+1 system clocks, so the divider value is the system clock over five times the wanted SCL rate, minus one. The core also watches the lines for start and stop conditions from any master, which gives a bus-busy flag. If SDA reads low while the core is leaving it high, the core gives up the bus and sets an arbitration-lost flag.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, offsets 0 and 1 (divider low and high byte) read 0xFF, offset 2 (control) reads 0x00, offset 4 (status) reads 0x00, irq_o is low and both SCL and SDA are released.
- R2: Writes to offsets 0, 1 and 2 read back unchanged. Offset 3 takes the byte to send on a write and returns the last byte received on a read.
- R3: During every bit of a byte, SCL stays high for exactly 3*(prescale+1) system clocks.
- R4: A command with bit 7 (start) set, such as 0x91, makes a start condition and then sends the data-register byte MSB first.
- R5: After a byte is written, status bit 7 holds the ninth bit sampled from SDA: 0 when the slave pulled it low (ACK), 1 otherwise (NACK).
- R6: Command bit 5 (read) clocks in eight bits, which then read back at offset 3. On the ninth bit the core drives SDA low when bit 3 is clear (0x21) and leaves it high when bit 3 is set (0x29).
- R7: Status bit 1 (transfer in progress) is high from the cycle after an accepted command until the sequence ends. Status bit 0 (interrupt flag) sets when a sequence ends, and a command write with bit 0 set clears it.
- R8: A command with only bit 6 (stop) set, 0x41, makes a stop condition and sets the interrupt flag.
- R9: Status bit 6 (bus busy) rises after a start condition is seen on the lines and falls after a stop condition is seen.
- R10: If SDA reads low while the core is sending a 1, status bit 5 and the interrupt flag set, transfer in progress clears and both lines are released.
- R11: irq_o equals the interrupt flag ANDed with control bit 6. Clearing control bit 6 leaves the flag itself unchanged.
- R12: While control bit 7 (core enable) is clear, a command write is ignored: transfer in progress stays low and SCL stays released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | Level sensed on the SCL line |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_i | input | 1 | Level sensed on the SDA line |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
The assertions assume that software issues a new command only after transfer in progress has cleared, and that the line inputs are clean, already-synchronous levels. The bench follows both rules. It polls status bit 1 after every command. It models the slave and a second contending device as pull-downs that change SDA only while SCL is low, so a start or stop condition is seen only when the core makes one, or during the arbitration case, when the contender lets go. The random part picks the divider from a small range and draws random bytes, acknowledge choices and stop merging, all from a fixed seed.

// File: rtl/iicm_pkg.sv
package iicm_pkg;

    localparam int AW        = 3;
    localparam int PHASES    = 5;
    localparam int PH_W      = $clog2(PHASES);
    localparam int LAST_PH   = PHASES - 1;
    localparam int SAMPLE_PH = 3;

    // register offsets
    localparam logic [AW-1:0] REG_PRE_LO = 3'd0;
    localparam logic [AW-1:0] REG_PRE_HI = 3'd1;
    localparam logic [AW-1:0] REG_CTRL   = 3'd2;
    localparam logic [AW-1:0] REG_DATA   = 3'd3;
    localparam logic [AW-1:0] REG_CMD    = 3'd4;

    // control bits
    localparam int CTL_EN  = 7;
    localparam int CTL_IEN = 6;

    // command bits
    localparam int CB_STA  = 7;
    localparam int CB_STO  = 6;
    localparam int CB_RD   = 5;
    localparam int CB_WR   = 4;
    localparam int CB_NACK = 3;
    localparam int CB_IACK = 0;

    // status bits
    localparam int ST_IF    = 0;
    localparam int ST_TIP   = 1;
    localparam int ST_AL    = 5;
    localparam int ST_BUSY  = 6;
    localparam int ST_RXACK = 7;

    typedef enum logic [1:0] {BC_START, BC_STOP, BC_WR, BC_RD} bit_cmd_e;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
        logic nack;
    } iicm_cmd_t;

    // {scl_high, sda_high} for one phase of one bit-level command
    function automatic logic [1:0] line_levels(input bit_cmd_e c,
                                               input logic [PH_W-1:0] ph,
                                               input logic d);
        logic [1:0] r;
        int p;
        p = int'(ph);
        r = 2'b11;
        case (c)
            BC_START: begin
                case (p)
                    0:       r = 2'b01;
                    1:       r = 2'b11;
                    2, 3:    r = 2'b10;
                    default: r = 2'b00;
                endcase
            end
            BC_STOP: begin
                case (p)
                    0:       r = 2'b00;
                    1, 2:    r = 2'b10;
                    default: r = 2'b11;
                endcase
            end
            default: r = {(p != 0) && (p != LAST_PH), d};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/iicm_rate_div.sv
module iicm_rate_div #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] reload,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (!en || cnt == '0)  cnt <= reload;
        else                        cnt <= cnt - 1'b1;
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && reload != '0 && $stable(reload)) |=> !tick);

endmodule

// File: rtl/iicm_bit_engine.sv
module iicm_bit_engine
    import iicm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     go,
    input  bit_cmd_e cmd,
    input  logic     din,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     scl_oe,
    output logic     sda_oe,
    output logic     done,
    output logic     dout,
    output logic     al,
    output logic     busy
);
    logic            active;
    logic [PH_W-1:0] phase;
    bit_cmd_e        cmd_q;
    logic            din_q;
    logic            scl_q, sda_q;
    logic [1:0]      lv;
    logic            lost;

    assign lv   = line_levels(cmd_q, phase, din_q);
    assign lost = (phase == PH_W'(SAMPLE_PH)) && (cmd_q == BC_WR) && din_q && !sda_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            phase  <= '0;
            cmd_q  <= BC_STOP;
            din_q  <= 1'b1;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            done   <= 1'b0;
            dout   <= 1'b1;
            al     <= 1'b0;
        end else begin
            done <= 1'b0;
            al   <= 1'b0;
            if (go && !active) begin
                active <= 1'b1;
                phase  <= '0;
                cmd_q  <= cmd;
                din_q  <= din;
            end else if (active && tick) begin
                if (lost) begin
                    al     <= 1'b1;
                    active <= 1'b0;
                    scl_oe <= 1'b0;
                    sda_oe <= 1'b0;
                end else begin
                    scl_oe <= !lv[1];
                    sda_oe <= !lv[0];
                    if (phase == PH_W'(SAMPLE_PH)) dout <= sda_i;
                    if (phase == PH_W'(LAST_PH)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        phase <= phase + PH_W'(1);
                    end
                end
            end
        end
    end

    // bus condition watcher
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            if (scl_i && scl_q && sda_q && !sda_i)      busy <= 1'b1;
            else if (scl_i && scl_q && !sda_q && sda_i) busy <= 1'b0;
        end
    end

    // R10
    arb_release_chk: assert property (@(posedge clk) disable iff (rst)
        al |=> (!scl_oe && !sda_oe));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (int'(phase) <= LAST_PH));

endmodule

// File: rtl/iicm_byte_engine.sv
module iicm_byte_engine
    import iicm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  iicm_cmd_t     cmd,
    input  logic [DW-1:0] txd,
    input  logic          bit_done,
    input  logic          bit_dout,
    input  logic          bit_al,
    output logic          bit_go,
    output bit_cmd_e      bit_cmd,
    output logic          bit_din,
    output logic          tip,
    output logic          done,
    output logic [DW-1:0] rxd,
    output logic          rxack
);
    localparam int CW = $clog2(DW);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_ACK, S_STOP} bstate_e;

    bstate_e       state;
    iicm_cmd_t     cq, cmd_n;
    logic [DW-1:0] sr, sr_n;
    logic [CW-1:0] cnt;

    always_comb begin
        cmd_n      = cmd;
        cmd_n.rd   = cmd.rd & ~cmd.sta;
        cmd_n.wr   = (cmd.wr | cmd.sta) & ~cmd_n.rd;
        sr_n       = cq.rd ? {sr[DW-2:0], bit_dout} : {sr[DW-2:0], 1'b0};
    end

    assign tip = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cq      <= '0;
            sr      <= '0;
            cnt     <= '0;
            bit_go  <= 1'b0;
            bit_cmd <= BC_STOP;
            bit_din <= 1'b1;
            done    <= 1'b0;
            rxd     <= '0;
            rxack   <= 1'b0;
        end else begin
            bit_go <= 1'b0;
            done   <= 1'b0;
            if (bit_al) begin
                state <= S_IDLE;
                done  <= 1'b1;
            end else begin
                case (state)
                    S_IDLE: if (go) begin
                        cq  <= cmd_n;
                        sr  <= txd;
                        cnt <= '0;
                        bit_go <= 1'b1;
                        if (cmd.sta) begin
                            state   <= S_START;
                            bit_cmd <= BC_START;
                            bit_din <= 1'b1;
                        end else if (cmd_n.rd || cmd_n.wr) begin
                            state   <= S_DATA;
                            bit_cmd <= cmd_n.rd ? BC_RD : BC_WR;
                            bit_din <= cmd_n.rd ? 1'b1 : txd[DW-1];
                        end else begin
                            state   <= S_STOP;
                            bit_cmd <= BC_STOP;
                            bit_din <= 1'b1;
                        end
                    end
                    S_START: if (bit_done) begin
                        state   <= S_DATA;
                        bit_go  <= 1'b1;
                        bit_cmd <= BC_WR;
                        bit_din <= sr[DW-1];
                    end
                    S_DATA: if (bit_done) begin
                        sr     <= sr_n;
                        bit_go <= 1'b1;
                        if (cnt == CW'(DW-1)) begin
                            state   <= S_ACK;
                            bit_cmd <= cq.rd ? BC_WR : BC_RD;
                            bit_din <= cq.rd ? cq.nack : 1'b1;
                        end else begin
                            cnt     <= cnt + CW'(1);
                            bit_din <= cq.rd ? 1'b1 : sr_n[DW-1];
                        end
                    end
                    S_ACK: if (bit_done) begin
                        if (cq.rd) rxd   <= sr;
                        else       rxack <= bit_dout;
                        if (cq.sto) begin
                            state   <= S_STOP;
                            bit_go  <= 1'b1;
                            bit_cmd <= BC_STOP;
                            bit_din <= 1'b1;
                        end else begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    S_STOP: if (bit_done) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R7
    done_from_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state != S_IDLE));

    // R7
    go_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> (state == S_IDLE));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import iicm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    input  logic          scl_i,
    output logic          scl_oe,
    input  logic          sda_i,
    output logic          sda_oe
);
    localparam int PRE_W = 2 * DW;

    logic [PRE_W-1:0] prer;
    logic [DW-1:0]    ctrl_q, txr, rxd, status;
    logic             iflag, al_flag;
    logic             core_en, ien, wr_cmd, go, tip, done, rxack;
    logic             tick, bit_go, bit_din, bit_done, bit_dout, bit_al, busy;
    bit_cmd_e         bit_cmd;
    iicm_cmd_t        cmd_in;

    assign core_en = ctrl_q[CTL_EN];
    assign ien     = ctrl_q[CTL_IEN];
    assign wr_cmd  = bus_wr && (bus_addr == REG_CMD);
    assign cmd_in  = '{sta:  bus_wdata[CB_STA],
                       sto:  bus_wdata[CB_STO],
                       rd:   bus_wdata[CB_RD],
                       wr:   bus_wdata[CB_WR],
                       nack: bus_wdata[CB_NACK]};
    assign go      = wr_cmd && core_en && !tip &&
                     (cmd_in.sta || cmd_in.sto || cmd_in.rd || cmd_in.wr);
    assign irq_o   = iflag & ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            prer    <= '1;
            ctrl_q  <= '0;
            txr     <= '0;
            iflag   <= 1'b0;
            al_flag <= 1'b0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    REG_PRE_LO: prer[DW-1:0]     <= bus_wdata;
                    REG_PRE_HI: prer[PRE_W-1:DW] <= bus_wdata;
                    REG_CTRL:   ctrl_q           <= bus_wdata;
                    REG_DATA:   txr              <= bus_wdata;
                    default: ;
                endcase
            end
            if (done)                              iflag <= 1'b1;
            else if (wr_cmd && bus_wdata[CB_IACK]) iflag <= 1'b0;
            if (bit_al)  al_flag <= 1'b1;
            else if (go) al_flag <= 1'b0;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_IF]    = iflag;
        status[ST_TIP]   = tip;
        status[ST_AL]    = al_flag;
        status[ST_BUSY]  = busy;
        status[ST_RXACK] = rxack;
        case (bus_addr)
            REG_PRE_LO: bus_rdata = prer[DW-1:0];
            REG_PRE_HI: bus_rdata = prer[PRE_W-1:DW];
            REG_CTRL:   bus_rdata = ctrl_q;
            REG_DATA:   bus_rdata = rxd;
            REG_CMD:    bus_rdata = status;
            default:    bus_rdata = '0;
        endcase
    end

    iicm_rate_div #(.CW(PRE_W)) u_div (
        .clk(clk), .rst(rst), .en(core_en), .reload(prer), .tick(tick)
    );

    iicm_byte_engine #(.DW(DW)) u_byte (
        .clk(clk), .rst(rst), .go(go), .cmd(cmd_in), .txd(txr),
        .bit_done(bit_done), .bit_dout(bit_dout), .bit_al(bit_al),
        .bit_go(bit_go), .bit_cmd(bit_cmd), .bit_din(bit_din),
        .tip(tip), .done(done), .rxd(rxd), .rxack(rxack)
    );

    iicm_bit_engine u_bit (
        .clk(clk), .rst(rst), .tick(tick), .go(bit_go), .cmd(bit_cmd),
        .din(bit_din), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(bit_done),
        .dout(bit_dout), .al(bit_al), .busy(busy)
    );

    // R1
    reset_prescale_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prer == '1 && ctrl_q == '0 && !scl_oe && !sda_oe));

    // R7
    iack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && bus_wdata[CB_IACK] && !done) |=> !iflag);

    // R12
    disabled_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !core_en && !tip) |=> !tip);

endmodule

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;

    logic       clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic [2:0] addr;
    logic       wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq, scl_oe, sda_oe;
    logic       slave_pull, contend;
    wire        scl_line = !scl_oe;
    wire        sda_line = !sda_oe && !slave_pull && !contend;

    i2c_byte_master uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_o(irq), .scl_i(scl_line), .scl_oe(scl_oe),
        .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int checks = 0;
    int fails  = 0;

    // slave model
    logic       scl_p, sda_p, slv_tx, ack_en, m_ack_seen;
    logic [7:0] srx, slv_last, slv_tx_byte;
    int         bitcnt, hi_cnt, hi_len;

    always @(negedge clk) begin
        logic cs, cd;
        cs = scl_line;
        cd = sda_line;
        if (rst) begin
            bitcnt = 0; hi_cnt = 0; hi_len = 0; slave_pull = 1'b0;
            srx = '0; slv_last = '0; m_ack_seen = 1'b1;
        end else begin
            if (!scl_p && cs) begin
                if (bitcnt < 8) srx = {srx[6:0], cd};
                if (bitcnt == 7) slv_last = srx;
                if (bitcnt == 8) m_ack_seen = cd;
                bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
            end
            if (cs) hi_cnt++;
            else begin
                if (scl_p) hi_len = hi_cnt;
                hi_cnt = 0;
            end
            if (scl_p && cs && sda_p && !cd) bitcnt = 0;
            if (scl_p && cs && !sda_p && cd) bitcnt = 0;
            if (!cs)
                slave_pull = (bitcnt == 8) ? (ack_en && !slv_tx)
                           : (slv_tx && !slv_tx_byte[7-bitcnt]);
        end
        scl_p = cs;
        sda_p = cd;
    end

    function automatic int exp_hi(input int p);
        return 3 * (p + 1);
    endfunction

    function automatic logic [7:0] cmd_byte(input logic sta, input logic sto,
                                            input logic rd, input logic wrb,
                                            input logic nack);
        return {sta, sto, rd, wrb, nack, 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            brd(3'd4, s);
            if (!s[1]) return;
        end
        chk("R7 tip never cleared", 32'd1, 32'd0);
    endtask

    task automatic set_pre(input int p);
        bwr(3'd0, 8'(p));
        bwr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R7 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int p, lows;
        void'($urandom(32'h5eed_1c2b));
        rst = 1'b1; addr = '0; wr = 1'b0; wdata = '0;
        contend = 1'b0; slv_tx = 1'b0; ack_en = 1'b1; slv_tx_byte = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        brd(3'd0, v); chk("R1 prescale low", v, 8'hFF);
        brd(3'd1, v); chk("R1 prescale high", v, 8'hFF);
        brd(3'd2, v); chk("R1 control", v, 8'h00);
        brd(3'd4, v); chk("R1 status", v, 8'h00);
        chk("R1 lines released", {scl_line, sda_line, irq}, 3'b110);

        // R2 readback
        bwr(3'd0, 8'h5C); bwr(3'd1, 8'hA3); bwr(3'd2, 8'h3F);
        brd(3'd0, v); chk("R2 prescale low", v, 8'h5C);
        brd(3'd1, v); chk("R2 prescale high", v, 8'hA3);
        brd(3'd2, v); chk("R2 control", v, 8'h3F);

        p = 2;
        set_pre(p);
        bwr(3'd2, 8'hC0);

        // R4 start + address write with ACK
        bwr(3'd3, 8'hA4);
        bwr(3'd4, 8'h91);
        brd(3'd4, v); chk("R7 tip after command", v[1], 1'b1);
        wait_idle();
        chk("R4 slave saw address", slv_last, 8'hA4);
        brd(3'd4, v);
        chk("R5 ack received", v[7], 1'b0);
        chk("R9 busy after start", v[6], 1'b1);
        chk("R7 flag after byte", v[0], 1'b1);
        chk("R11 irq with enable", irq, 1'b1);
        chk("R3 scl high time", hi_len, exp_hi(p));
        bwr(3'd4, 8'h01);
        brd(3'd4, v); chk("R7 flag cleared by ack", v[0], 1'b0);

        // R5 nack on a data byte
        ack_en = 1'b0;
        bwr(3'd3, 8'h5A);
        bwr(3'd4, 8'h11);
        wait_idle();
        chk("R4 slave saw data", slv_last, 8'h5A);
        brd(3'd4, v); chk("R5 nack received", v[7], 1'b1);
        ack_en = 1'b1;

        // R11 clearing interrupt enable keeps flag
        bwr(3'd2, 8'h80);
        brd(3'd4, v);
        chk("R11 irq masked", irq, 1'b0);
        chk("R11 flag kept", v[0], 1'b1);
        bwr(3'd2, 8'hC0);
        #1 chk("R11 irq restored", irq, 1'b1);
        bwr(3'd4, 8'h01);

        // R8 stop alone
        bwr(3'd4, 8'h41);
        wait_idle();
        brd(3'd4, v);
        chk("R8 flag after stop", v[0], 1'b1);
        chk("R9 busy cleared by stop", v[6], 1'b0);
        chk("R8 lines released", {scl_line, sda_line}, 2'b11);
        bwr(3'd4, 8'h01);

        // random transactions
        for (int it = 0; it < 10; it++) begin
            logic [7:0] ad, db;
            logic do_rd, nk, ak, merge;
            p     = int'($urandom % 4);
            ad    = 8'($urandom);
            db    = 8'($urandom);
            do_rd = 1'($urandom);
            nk    = 1'($urandom);
            ak    = 1'($urandom);
            merge = 1'($urandom);
            set_pre(p);
            ack_en = 1'b1;
            bwr(3'd3, {ad[7:1], do_rd});
            bwr(3'd4, cmd_byte(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
            wait_idle();
            chk("R4 random address", slv_last, {ad[7:1], do_rd});
            brd(3'd4, v); chk("R5 random address ack", v[7], 1'b0);
            if (do_rd) begin
                slv_tx_byte = db;
                slv_tx = 1'b1;
                bwr(3'd4, cmd_byte(1'b0, 1'b0, 1'b1, 1'b0, nk));
                wait_idle();
                slv_tx = 1'b0;
                brd(3'd3, v); chk("R6 read byte", v, db);
                chk("R6 master ack bit", m_ack_seen, nk);
                chk("R3 scl high time on read", hi_len, exp_hi(p));
                bwr(3'd4, 8'h41);
                wait_idle();
            end else begin
                ack_en = ak;
                bwr(3'd3, db);
                bwr(3'd4, cmd_byte(1'b0, merge, 1'b0, 1'b1, 1'b0));
                wait_idle();
                chk("R4 random data", slv_last, db);
                brd(3'd4, v); chk("R5 random data ack", v[7], !ak);
                if (!merge) begin
                    chk("R3 scl high time on write", hi_len, exp_hi(p));
                    bwr(3'd4, 8'h41);
                    wait_idle();
                end
            end
            repeat (3) @(negedge clk);
            brd(3'd4, v);
            chk("R9 busy after final stop", v[6], 1'b0);
            chk("R7 flag at end", v[0], 1'b1);
            bwr(3'd4, 8'h01);
        end

        // R10 arbitration lost
        set_pre(1);
        ack_en = 1'b1;
        bwr(3'd3, 8'h20);
        bwr(3'd4, 8'h91);
        wait_idle();
        bwr(3'd4, 8'h01);
        contend = 1'b1;
        bwr(3'd3, 8'hFF);
        bwr(3'd4, 8'h11);
        wait_idle();
        brd(3'd4, v);
        chk("R10 lost flag", v[5], 1'b1);
        chk("R10 interrupt flag", v[0], 1'b1);
        chk("R10 tip clear", v[1], 1'b0);
        chk("R10 scl released", {scl_oe, sda_oe}, 2'b00);
        contend = 1'b0;
        repeat (4) @(negedge clk);
        brd(3'd4, v); chk("R9 busy cleared after release", v[6], 1'b0);
        bwr(3'd4, 8'h01);

        // R12 disabled core ignores commands
        bwr(3'd2, 8'h00);
        bwr(3'd3, 8'h55);
        bwr(3'd4, 8'h91);
        brd(3'd4, v); chk("R12 tip stays low", v[1], 1'b0);
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!scl_line) lows++;
        end
        chk("R12 scl idle", lows, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule